// File: doc/BRIEF.md
# Sticky-Collecting Mantissa Right Shifter

This block shifts a wide floating-point mantissa to the right by a variable number of bit positions. The mantissa is carried as four 32-bit words on a single 128-bit bus. Every bit that leaves the bottom of the bus is not lost. It is folded into a single sticky bit, together with a sticky bit that arrives with the operand, so that a later rounding stage can still see that something non-zero was discarded. An alignment step in an adder, or a denormalising step, uses the block to bring one operand down to the exponent of the other.

The shift is done in two steps. A coarse step moves whole 32-bit words downward. A fine step then moves the bits by the remaining 0 to 31 positions. A shift amount at or beyond the mantissa width (parameter, 115 bits by default) takes a short path that clears the mantissa and forces the sticky bit to 1. A shift amount of zero is not legal. It passes the operand through untouched and raises an error flag.

The result leaves the block through a valid/ready port. A parameter makes that port either a single output register or a direct combinational path.

Top module: `mant_rshift_sticky`

## Requirements
- R1: Word 0 of the mantissa occupies bus bits 127:96 and word 3 occupies bits 31:0. For 1 <= shift < MANT_W, the output mantissa equals the input bus shifted right logically by the shift amount, with zeros filling from the top.
- R2: For 1 <= shift < MANT_W, the output sticky is 1 exactly when the input sticky is 1 or at least one of the low `shift` bits of the input bus is 1.
- R3: For a shift >= MANT_W (115 by default, with an 8-bit shift input), the output mantissa is all zeros, the output sticky is 1 and the error flag is 0, whatever the mantissa and input sticky are.
- R4: For a shift of 0, the output mantissa equals the input mantissa, the output sticky equals the input sticky, and the error flag is 1.
- R5: The error flag is 0 for every non-zero shift amount.
- R6: For a shift that is a non-zero multiple of 32, only whole words move. The sticky then collects only the dropped words and the input sticky.
- R7: With REGISTERED=1, an operand accepted on a clock edge (in_valid and in_ready both high) appears at the output with out_valid high after that edge. While out_valid is high and out_ready is low, the output is held stable. in_ready equals (not out_valid) or out_ready.
- R8: With REGISTERED=0, the outputs follow the inputs in the same cycle, out_valid equals in_valid and in_ready equals out_ready.
- R9: While rst_n is low and after the first clock edge, out_valid is 0 in registered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand |
| in_mant | input | 128 | Mantissa, word 0 in the top 32 bits |
| in_sticky | input | 1 | Sticky bit carried with the operand |
| in_shamt | input | 8 | Right shift amount in bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_mant | output | 128 | Shifted mantissa |
| out_sticky | output | 1 | Input sticky ORed with every discarded bit |
| out_err | output | 1 | Shift amount of zero was requested |

## Verification
The bench aims at the word boundaries: 31, 32, 33, 63, 64, 95, 96 and the last legal amount 114. A wrong coarse selector would misplace whole words there. A wrong residual mask would leak or lose the lowest discarded bit into the sticky bit. Shifts of 115 and of 255 check the clear-and-force path, including a zero mantissa with a clear input sticky, which must still produce sticky 1. A zero shift checks that the error flag rises and the operand passes through untouched. Randomly dropped out_ready exposes an output register that changes while stalled or that drops results.

// File: rtl/mrs_pkg.sv
// Package: shared widths for the mantissa right shifter.
// Assumes the mantissa bus is a whole number of equal words.
package mrs_pkg;
    localparam int WORD_W   = 32;
    localparam int N_WORDS  = 4;
    localparam int BUS_W    = WORD_W * N_WORDS;
    localparam int LOG_W    = $clog2(WORD_W);

    typedef logic [BUS_W-1:0] mant_t;

    typedef struct packed {
        mant_t mant;
        logic  sticky;
        logic  err;
    } shres_t;
endpackage

// File: rtl/mrs_word_mover.sv
// Coarse stage: moves whole words toward the low end of the bus by
// nwords places and zero-fills the vacated upper words. It reports
// whether any dropped word held a set bit.
// Assumes word 0 sits in the most significant bits of the bus.
module mrs_word_mover #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 4,
    parameter int MOVE_W  = 3,
    localparam int BUS_W  = WORD_W * N_WORDS
) (
    input  logic [BUS_W-1:0]  din,
    input  logic [MOVE_W-1:0] nwords,
    output logic [BUS_W-1:0]  dout,
    output logic              lost
);
    // Word move and drop detection, word by word.
    always_comb begin
        dout = '0;
        lost = 1'b0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (i >= int'(nwords)) begin
                dout[(N_WORDS-i)*WORD_W-1 -: WORD_W] =
                    din[(N_WORDS-(i-int'(nwords)))*WORD_W-1 -: WORD_W];
            end
            if (i >= N_WORDS - int'(nwords)) begin
                lost = lost | (|din[(N_WORDS-i)*WORD_W-1 -: WORD_W]);
            end
        end
    end

    // The top word must be empty once anything moved.
    always_comb begin
        if (nwords != '0) begin
            AST_TOP_WORD_EMPTY: assert (dout[BUS_W-1 -: WORD_W] == '0); // R1
        end
    end
endmodule

// File: rtl/mrs_bit_shift.sv
// Fine stage: shifts the whole bus right by 0 to WORD_W-1 bits and
// reports whether any bit that fell off the low word was set.
// Assumes the shift input is narrower than a word index.
module mrs_bit_shift #(
    parameter int BUS_W  = 128,
    parameter int WORD_W = 32,
    localparam int SH_W  = $clog2(WORD_W)
) (
    input  logic [BUS_W-1:0] din,
    input  logic [SH_W-1:0]  shift,
    output logic [BUS_W-1:0] dout,
    output logic             lost
);
    logic [WORD_W-1:0] low_mask;

    // Mask of the low bits that leave the bus.
    always_comb low_mask = (WORD_W'(1) << shift) - WORD_W'(1);

    // Shifted bus and fall-off detection.
    always_comb begin
        dout = din >> shift;
        lost = |(din[WORD_W-1:0] & low_mask);
    end

    // A zero residual must leave the words as they are.
    always_comb begin
        if (shift == '0) begin
            AST_FINE_ZERO_IDLE: assert (dout == din && !lost); // R6
        end
    end
endmodule

// File: rtl/mrs_out_stage.sv
// Output stage: either a single valid/ready register or a straight
// wire, chosen by REGISTERED.
// Assumes the producer holds data stable while in_valid is high.
module mrs_out_stage #(
    parameter int DATA_W     = 130,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    generate
        if (REGISTERED) begin : g_reg
            logic              vld_q;
            logic [DATA_W-1:0] dat_q;

            // Free when empty or when the consumer takes the result.
            always_comb in_ready = !vld_q || out_ready;

            // Holding register with synchronous active-low reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= 1'b0;
                    dat_q <= '0;
                end else if (in_ready) begin
                    vld_q <= in_valid;
                    if (in_valid) dat_q <= in_data;
                end
            end

            assign out_valid = vld_q;
            assign out_data  = dat_q;

            AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && in_ready |=> out_valid && out_data == $past(in_data)); // R7
            AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
        end else begin : g_comb
            assign in_ready  = out_ready;
            assign out_valid = in_valid;
            assign out_data  = in_data;

            AST_COMB_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && out_ready |-> in_valid && in_ready); // R8
        end
    endgenerate
endmodule

// File: rtl/mant_rshift_sticky.sv
// Top: right shifter for a multi-word mantissa with sticky collection.
// A coarse word move is followed by a fine bit move. Shifts at or
// beyond MANT_W clear the mantissa and force sticky. A zero shift
// passes the operand through and flags an error.
// Assumes MANT_W <= bus width and the shift input can express MANT_W.
module mant_rshift_sticky
    import mrs_pkg::*;
#(
    parameter int MANT_W     = 115,
    parameter int SHAMT_W    = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BUS_W-1:0]   in_mant,
    input  logic               in_sticky,
    input  logic [SHAMT_W-1:0] in_shamt,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [BUS_W-1:0]   out_mant,
    output logic               out_sticky,
    output logic               out_err
);
    localparam int MOVE_W = SHAMT_W - LOG_W;
    localparam int DATA_W = BUS_W + 2;
    localparam logic [SHAMT_W-1:0] BIG_AT = SHAMT_W'(MANT_W);

    logic               is_zero, is_big;
    logic [MOVE_W-1:0]  nwords;
    logic [LOG_W-1:0]   resid;
    logic [BUS_W-1:0]   moved, fine;
    logic               move_lost, fine_lost;
    shres_t             res, res_q;

    // Split the shift amount into its word and bit parts.
    always_comb begin
        is_zero = (in_shamt == '0);
        is_big  = (in_shamt >= BIG_AT);
        nwords  = is_big ? '0 : in_shamt[SHAMT_W-1:LOG_W];
        resid   = in_shamt[LOG_W-1:0];
    end

    mrs_word_mover #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .MOVE_W(MOVE_W)) u_move (
        .din(in_mant), .nwords(nwords), .dout(moved), .lost(move_lost)
    );

    mrs_bit_shift #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_fine (
        .din(moved), .shift(resid), .dout(fine), .lost(fine_lost)
    );

    // Pick the pass-through, clear or shifted result.
    always_comb begin
        if (is_zero) begin
            res.mant = in_mant; res.sticky = in_sticky; res.err = 1'b1;
        end else if (is_big) begin
            res.mant = '0; res.sticky = 1'b1; res.err = 1'b0;
        end else begin
            res.mant   = fine;
            res.sticky = in_sticky | move_lost | fine_lost;
            res.err    = 1'b0;
        end
    end

    mrs_out_stage #(.DATA_W(DATA_W), .REGISTERED(REGISTERED)) u_out (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(res),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(res_q)
    );

    assign out_mant   = res_q.mant;
    assign out_sticky = res_q.sticky;
    assign out_err    = res_q.err;

    AST_ZERO_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_shamt == '0 |-> res.err && res.mant == in_mant && res.sticky == in_sticky); // R4
    AST_BIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_shamt >= BIG_AT |-> res.mant == '0 && res.sticky && !res.err); // R3
    AST_STICKY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sticky |-> res.sticky); // R2
    AST_ERR_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_shamt != '0 |-> !res.err); // R5
endmodule

// File: tb/mant_rshift_sticky_tb_top.sv
// Bench: behavioural reference model, expected-result queue for the
// registered instance, same-cycle check for the combinational one.
module mant_rshift_sticky_tb_top;
    localparam int MW = 115;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_mant = '0;
    logic         in_sticky = 1'b0;
    logic [7:0]   in_shamt = 8'd1;
    logic         out_ready = 1'b0;

    logic         r_in_ready, r_out_valid, r_out_sticky, r_out_err;
    logic [127:0] r_out_mant;
    logic         c_in_ready, c_out_valid, c_out_sticky, c_out_err;
    logic [127:0] c_out_mant;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic [129:0] exp_q[$];
    string        tag_q[$];

    always #4 clk = ~clk;

    mant_rshift_sticky #(.REGISTERED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(r_in_ready),
        .in_mant(in_mant), .in_sticky(in_sticky), .in_shamt(in_shamt),
        .out_valid(r_out_valid), .out_ready(out_ready), .out_mant(r_out_mant),
        .out_sticky(r_out_sticky), .out_err(r_out_err)
    );

    mant_rshift_sticky #(.REGISTERED(1'b0)) dut_c (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
        .in_mant(in_mant), .in_sticky(in_sticky), .in_shamt(in_shamt),
        .out_valid(c_out_valid), .out_ready(out_ready), .out_mant(c_out_mant),
        .out_sticky(c_out_sticky), .out_err(c_out_err)
    );

    // Reference: {err, sticky, mant} from the requirements.
    function automatic logic [129:0] model(input logic [127:0] m, input logic s,
                                           input logic [7:0] sh);
        logic st;
        if (sh == 8'd0) return {1'b1, s, m};                 // R4
        if (int'(sh) >= MW) return {1'b0, 1'b1, 128'd0};     // R3
        st = s;
        for (int b = 0; b < int'(sh); b++) if (m[b]) st = 1'b1; // R2
        return {1'b0, st, m >> sh};                          // R1 R5
    endfunction

    function automatic string tag_of(input logic [7:0] sh);
        if (sh == 8'd0) return "R4";
        if (int'(sh) >= MW) return "R3";
        if (sh[4:0] == 5'd0) return "R6";
        return "R1 R2 R5";
    endfunction

    task automatic check(input string tag, input logic [129:0] act,
                         input logic [129:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual err=%b st=%b m=%h expected err=%b st=%b m=%h",
                     tag, act[129], act[128], act[127:0], exp[129], exp[128], exp[127:0]);
        end
    endtask

    // One cycle: check outputs, drive the next inputs, track handshakes.
    task automatic step(input logic v, input logic [127:0] m, input logic s,
                        input logic [7:0] sh, input logic rdy);
        @(negedge clk);
        if (r_out_valid) begin
            if (exp_q.size() == 0) check("R7 spurious valid", {2'b0, 128'd0}, {2'b11, 128'd0});
            else check({tag_q[0], " R7 reg"}, {r_out_err, r_out_sticky, r_out_mant}, exp_q[0]);
        end
        in_valid = v; in_mant = m; in_sticky = s; in_shamt = sh; out_ready = rdy;
        #1;
        check("R7 in_ready", {129'd0, r_in_ready}, {129'd0, (!r_out_valid || out_ready)});
        check("R8 comb flow", {128'd0, c_out_valid, c_in_ready}, {128'd0, in_valid, out_ready});
        if (v) check({tag_of(sh), " R8 comb"}, {c_out_err, c_out_sticky, c_out_mant}, model(m, s, sh));
        if (r_out_valid && out_ready) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
        if (v && r_in_ready) begin
            exp_q.push_back(model(m, s, sh));
            tag_q.push_back(tag_of(sh));
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual cycles=%0d expected fewer", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] pat;
        logic [7:0] dir[] = '{8'd1, 8'd31, 8'd32, 8'd33, 8'd63, 8'd64, 8'd95,
                              8'd96, 8'd100, 8'd114, 8'd115, 8'd200, 8'd255, 8'd0};
        pat = 128'h8000_0001_F00D_CAFE_0000_0000_DEAD_BEEF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 reset idle", {129'd0, r_out_valid}, 130'd0);
        rst_n = 1'b1;
        // Directed boundary shifts, sticky in both states, with stalls.
        foreach (dir[i]) begin
            step(1'b1, pat, 1'b0, dir[i], 1'b1);
            step(1'b1, pat, 1'b1, dir[i], 1'b0);
        end
        // Zero mantissa, big shift: sticky still forced (R3).
        step(1'b1, 128'd0, 1'b0, 8'd115, 1'b1);
        // Only the lowest bit set: lost at shift 1 (R2), exact words (R6).
        step(1'b1, 128'd1, 1'b0, 8'd1, 1'b1);
        step(1'b1, 128'd1, 1'b0, 8'd32, 1'b1);
        step(1'b1, {96'd0, 32'h8000_0000}, 1'b0, 8'd31, 1'b1);
        step(1'b1, {32'hFFFF_FFFF, 96'd0}, 1'b0, 8'd64, 1'b1);
        // Random operands, amounts and backpressure.
        for (int k = 0; k < 400; k++) begin
            step(($urandom % 4) != 0,
                 {$urandom, $urandom, $urandom, $urandom} & {4{($urandom % 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF}},
                 1'($urandom % 2), 8'($urandom % 130), ($urandom % 3) != 0);
        end
        // Drain.
        for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b0, 8'd1, 1'b1);
        check("R7 drained", {98'd0, 32'(exp_q.size())}, 130'd0);
        // Reset again while data is held (R9).
        step(1'b1, pat, 1'b0, 8'd3, 1'b0);
        step(1'b0, pat, 1'b0, 8'd3, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears", {129'd0, r_out_valid}, 130'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule